// File: doc/BRIEF.md
# Latched Alarm Status Interrupt Register

This block gathers the line alarms of a two-channel line interface and presents them to a host as two 8-bit status words. Each word shows the present loss-of-signal and alarm-indication conditions next to sticky flags. A sticky flag records that an event took place at some point since the host last read that word. The event inputs are loss of signal, alarm indication, bipolar violation and pulse overflow for each channel, plus a device-reset event and a clock-lost condition. All of them are single-bit signals, synchronous to `clk`.

The host reads through a one-cycle strobe and an address. Address 0x10 selects channel 1 (index 0) and address 0x11 selects channel 2 (index 1). The word read out is the value held before the read. The read then clears that word's sticky flags; the live bits are not touched. An active-high interrupt output stays raised while either channel holds a pending interrupt flag.

An alarm-indication condition raises an interrupt both when it begins and when it ends. Loss of signal raises one only when it begins.

Top module: `alm_status_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every sticky flag, every registered live bit, `rd_data` and `irq` are 0 after that edge.
- R2: Bit 7 (live LOS) and bit 5 (live AIS) show the level that `los_in` and `ais_in` had at the previous clock edge. A read never clears them.
- R3: Bit 6 (latched LOS) sets on the clock edge that first sees `los_in` high after it was low. It stays set until that channel's word is read. A level held high through a read does not set it again.
- R4: Bit 4 (latched AIS) sets on a rising edge of `ais_in`. A falling edge of `ais_in` sets bit 0 (interrupt pending) and leaves bit 4 unchanged.
- R5: Bit 3 (latched BPV) and bit 2 (latched overflow) set on every clock edge at which `bpv_in` or `ovf_in`, respectively, is high.
- R6: Bit 1 of the word at 0x10 latches `dev_rst_evt`. Bit 1 of the word at 0x11 latches `clk_lost`. Each sets on every edge at which its input is high.
- R7: Bit 0 sets whenever any of bits 6, 4, 3, 2 or 1 of the same word is being set, and on an AIS falling edge.
- R8: A read at a clock edge with `rd_en` high makes `rd_data` after that edge equal to the addressed word as held before the edge, and clears bits 6, 4, 3, 2, 1 and 0 of that word only. Any other address returns 0 and clears nothing. `rd_data` holds while `rd_en` is low.
- R9: A flag whose set condition occurs at the same edge as a clearing read of its word is set after that edge.
- R10: `irq` is high exactly when bit 0 of either word is set. It falls only after every word with bit 0 set has been read.
- R11: An LOS or AIS pulse lasting one cycle, entirely between two reads, is reported as latched, with bit 0 set, by the second read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| los_in | input | 2 | Loss-of-signal condition per channel |
| ais_in | input | 2 | Alarm-indication condition per channel |
| bpv_in | input | 2 | Bipolar-violation event per channel |
| ovf_in | input | 2 | Pulse-overflow event per channel |
| dev_rst_evt | input | 1 | Device reset event (channel 1 word, bit 1) |
| clk_lost | input | 1 | Transmit or reference clock absent (channel 2 word, bit 1) |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Word returned by the last read |
| irq | output | 1 | Interrupt request, active high |

## Verification
The two functions that can coincide are the clearing read of a word and the setting of one of its sticky flags in the same cycle. If the clear won, an event would be lost. The bench provokes this on purpose by pulsing a violation or an LOS edge in the exact cycle the read strobe is high, and a random phase produces it again many times. The behavioural reference model lets the set win. The result is judged by the following read, which must show the flag, and by `irq` staying high.

// File: rtl/alm_stat_pkg.sv
// Package: shared constants and types of the alarm status block.
// Assumes two channels and an 8-bit word whose bit order software decodes.
package alm_stat_pkg;
    localparam int              NUM_CH    = 2;
    localparam int              DATA_W    = 8;
    localparam int              ADDR_W    = 8;
    localparam logic [7:0]      BASE_ADDR = 8'h10;
    localparam int              NUM_STICKY = 5;

    // Bit positions of the status word (fixed by the software decode)
    localparam int B_LIVE_LOS = 7;
    localparam int B_LAT_LOS  = 6;
    localparam int B_LIVE_AIS = 5;
    localparam int B_LAT_AIS  = 4;
    localparam int B_LAT_BPV  = 3;
    localparam int B_LAT_OVF  = 2;
    localparam int B_LAT_AUX  = 1;
    localparam int B_INT      = 0;

    // Per-channel event inputs
    typedef struct packed {
        logic los;
        logic ais;
        logic bpv;
        logic ovf;
        logic aux;
    } chan_evt_t;

    // Status word, packed so that field order equals bit order 7..0
    typedef struct packed {
        logic live_los;
        logic lat_los;
        logic live_ais;
        logic lat_ais;
        logic lat_bpv;
        logic lat_ovf;
        logic lat_aux;
        logic int_pend;
    } chan_stat_t;
endpackage

// File: rtl/alm_edge_det.sv
// Module: registered copy of level inputs with rise and fall strobes.
// Assumes the inputs are synchronous to clk; the strobes are combinational.
module alm_edge_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] q_r;

    // Keep last cycle's level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
    end

    assign q    = q_r;
    assign rise = d & ~q_r;
    assign fall = ~d & q_r;
endmodule

// File: rtl/alm_sticky.sv
// Module: a vector of set-dominant sticky flags with one common clear.
// Assumes set and clear are synchronous; a set in the clear cycle wins.
module alm_sticky #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Hold the flag until a clear with no coincident set
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= set[i] | (q[i] & ~clr);
        end
    end
endmodule

// File: rtl/alm_chan_status.sv
// Module: status word of one channel, with live bits, sticky latches and interrupt flag.
// Assumes clr is a one-cycle pulse from the read decoder for this channel.
module alm_chan_status
    import alm_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  chan_evt_t  evt,
    input  logic       clr,
    output chan_stat_t stat
);
    logic [1:0] lvl_q, lvl_rise, lvl_fall;
    logic [NUM_STICKY-1:0] set_vec, lat_q;
    logic                  int_set;
    logic [0:0]            int_q;

    // Bit 1 is AIS, bit 0 is LOS
    alm_edge_det #(.W(2)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({evt.ais, evt.los}),
        .q    (lvl_q),
        .rise (lvl_rise),
        .fall (lvl_fall)
    );

    // Order: LOS onset, AIS onset, BPV, overflow, auxiliary
    assign set_vec = {lvl_rise[0], lvl_rise[1], evt.bpv, evt.ovf, evt.aux};
    assign int_set = (|set_vec) | lvl_fall[1];

    alm_sticky #(.W(NUM_STICKY)) u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_vec),
        .clr  (clr),
        .q    (lat_q)
    );

    alm_sticky #(.W(1)) u_int (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (int_set),
        .clr  (clr),
        .q    (int_q)
    );

    // Assemble the word in software bit order
    always_comb begin
        stat.live_los = lvl_q[0];
        stat.lat_los  = lat_q[4];
        stat.live_ais = lvl_q[1];
        stat.lat_ais  = lat_q[3];
        stat.lat_bpv  = lat_q[2];
        stat.lat_ovf  = lat_q[1];
        stat.lat_aux  = lat_q[0];
        stat.int_pend = int_q[0];
    end
endmodule

// File: rtl/alm_read_port.sv
// Module: address decode, read data register and per-channel clear pulses.
// Assumes one-cycle read strobes; unknown addresses read zero and clear nothing.
module alm_read_port #(
    parameter int              NUM_CH    = 2,
    parameter int              DATA_W    = 8,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  words,
    output logic [NUM_CH-1:0]              clr,
    output logic [DATA_W-1:0]              rd_data
);
    logic [NUM_CH-1:0] hit;
    logic [DATA_W-1:0] sel_word;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + c);
        assign hit[c] = rd_en && (rd_addr == MY_ADDR);
    end

    assign clr = hit;

    // Pick the addressed word, zero when nothing matches
    always_comb begin
        sel_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit[c]) sel_word = words[c];
        end
    end

    // Capture the pre-clear word on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_word;
    end
endmodule

// File: rtl/alm_status_top.sv
// Module: two-channel latched alarm status with clear-on-read and interrupt.
// Assumes all inputs synchronous to clk; reset is synchronous, active low.
module alm_status_top
    import alm_stat_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CH-1:0]   los_in,
    input  logic [NUM_CH-1:0]   ais_in,
    input  logic [NUM_CH-1:0]   bpv_in,
    input  logic [NUM_CH-1:0]   ovf_in,
    input  logic                dev_rst_evt,
    input  logic                clk_lost,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq
);
    logic [NUM_CH-1:0][DATA_W-1:0] stat_w;
    logic [NUM_CH-1:0]             clr;
    logic [NUM_CH-1:0]             aux_in;
    logic [NUM_CH-1:0]             int_vec;

    // Channel index 0 carries the reset event, index 1 the clock-lost flag
    assign aux_in = {clk_lost, dev_rst_evt};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_evt_t  evt;
        chan_stat_t st;

        assign evt.los = los_in[c];
        assign evt.ais = ais_in[c];
        assign evt.bpv = bpv_in[c];
        assign evt.ovf = ovf_in[c];
        assign evt.aux = aux_in[c];

        alm_chan_status u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (evt),
            .clr  (clr[c]),
            .stat (st)
        );

        assign stat_w[c]  = st;
        assign int_vec[c] = st.int_pend;
    end

    alm_read_port #(
        .NUM_CH   (NUM_CH),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .words  (stat_w),
        .clr    (clr),
        .rd_data(rd_data)
    );

    assign irq = |int_vec;
endmodule

// File: rtl/alm_status_chk.sv
// Checker: temporal properties of the alarm status block, bound to the top.
// Assumes it sees the top's ports and its internal status words.
module alm_status_chk
    import alm_stat_pkg::*;
(
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_CH-1:0]             los_in,
    input logic [NUM_CH-1:0]             ais_in,
    input logic [NUM_CH-1:0]             bpv_in,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             rd_addr,
    input logic [DATA_W-1:0]             rd_data,
    input logic                          irq,
    input logic [NUM_CH-1:0][DATA_W-1:0] stat_w
);
    assert_rst_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq && rd_data == '0));

    assert_live_los_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stat_w[0][B_LIVE_LOS] == $past(los_in[0])));

    assert_los_onset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && los_in[0] && !stat_w[0][B_LIVE_LOS]) |-> stat_w[0][B_LAT_LOS]);

    assert_ais_fall_int_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !ais_in[1] && stat_w[1][B_LIVE_AIS]) |-> stat_w[1][B_INT]);

    assert_read_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_en && rd_addr == BASE_ADDR) |-> (rd_data == $past(stat_w[0])));

    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_en && rd_addr == BASE_ADDR && !bpv_in[0]) |-> !stat_w[0][B_LAT_BPV]);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && rd_en && rd_addr == BASE_ADDR && bpv_in[0]) |-> stat_w[0][B_LAT_BPV]);

    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && irq && !rd_en) |-> irq);
endmodule

bind alm_status_top alm_status_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .los_in (los_in),
    .ais_in (ais_in),
    .bpv_in (bpv_in),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .irq    (irq),
    .stat_w (stat_w)
);

// File: tb/alm_status_top_tb.sv
// Bench: behavioural reference model compared with the design every clock.
module alm_status_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] los_in = '0, ais_in = '0, bpv_in = '0, ovf_in = '0;
    logic       dev_rst_evt = 1'b0, clk_lost = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;

    int    vectors = 0;
    int    misses  = 0;
    int    cycles  = 0;
    bit    cmp_on  = 0;
    bit    done    = 0;
    string phase   = "R1";

    // Reference model state
    bit m_live_los[2], m_live_ais[2];
    bit m_llos[2], m_lais[2], m_lbpv[2], m_lovf[2], m_laux[2], m_int[2];
    logic [7:0] m_rd = '0;

    always #4 clk = ~clk;

    alm_status_top u_dut (
        .clk(clk), .rst_n(rst_n), .los_in(los_in), .ais_in(ais_in),
        .bpv_in(bpv_in), .ovf_in(ovf_in), .dev_rst_evt(dev_rst_evt),
        .clk_lost(clk_lost), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [7:0] m_word(int c);
        return {m_live_los[c], m_llos[c], m_live_ais[c], m_lais[c],
                m_lbpv[c], m_lovf[c], m_laux[c], m_int[c]};
    endfunction

    // Model update at each rising edge from the stable inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rd = '0;
            for (int c = 0; c < 2; c++) begin
                m_live_los[c] = 0; m_live_ais[c] = 0; m_llos[c] = 0; m_lais[c] = 0;
                m_lbpv[c] = 0; m_lovf[c] = 0; m_laux[c] = 0; m_int[c] = 0;
            end
        end else begin
            if (rd_en) begin
                if (rd_addr == 8'h10)      m_rd = m_word(0);
                else if (rd_addr == 8'h11) m_rd = m_word(1);
                else                       m_rd = '0;
            end
            for (int c = 0; c < 2; c++) begin
                bit up_los, up_ais, dn_ais, aux, clr, any;
                up_los = los_in[c] && !m_live_los[c];
                up_ais = ais_in[c] && !m_live_ais[c];
                dn_ais = !ais_in[c] && m_live_ais[c];
                aux    = (c == 0) ? dev_rst_evt : clk_lost;
                clr    = rd_en && (rd_addr == 8'(16 + c));
                any    = up_los || up_ais || bpv_in[c] || ovf_in[c] || aux || dn_ais;
                m_llos[c] = up_los    || (m_llos[c] && !clr);
                m_lais[c] = up_ais    || (m_lais[c] && !clr);
                m_lbpv[c] = bpv_in[c] || (m_lbpv[c] && !clr);
                m_lovf[c] = ovf_in[c] || (m_lovf[c] && !clr);
                m_laux[c] = aux       || (m_laux[c] && !clr);
                m_int[c]  = any       || (m_int[c] && !clr);
                m_live_los[c] = los_in[c];
                m_live_ais[c] = ais_in[c];
            end
        end
    end

    // Compare outputs away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cmp_on && !done) begin
            bit m_irq;
            m_irq = m_int[0] || m_int[1];
            vectors++;
            if (irq !== m_irq) begin
                misses++;
                $display("FAIL %s cycle %0d: irq actual %0b expected %0b", phase, cycles, irq, m_irq);
            end
            if (rd_data !== m_rd) begin
                misses++;
                $display("FAIL %s cycle %0d: rd_data actual %02h expected %02h", phase, cycles, rd_data, m_rd);
            end
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_read(logic [7:0] a);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    // Watchdog: an expired run is a failed check
    initial begin
        wait_cyc(100000);
        misses++;
        $display("FAIL watchdog: actual hung, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        wait_cyc(3);
        cmp_on = 1;
        @(negedge clk); rst_n = 1'b1;
        do_read(8'h10); do_read(8'h11);

        // R2: live LOS follows input and survives a read
        phase = "R2";
        @(negedge clk); los_in[0] = 1'b1;
        wait_cyc(2); do_read(8'h10); do_read(8'h10);

        // R3: held level does not relatch; drop and rise relatches
        phase = "R3";
        @(negedge clk); los_in[0] = 1'b0;
        wait_cyc(2); do_read(8'h10);
        @(negedge clk); los_in[0] = 1'b1;
        wait_cyc(3); do_read(8'h10); do_read(8'h10);
        @(negedge clk); los_in[0] = 1'b0;
        do_read(8'h10);

        // R4: AIS onset latches, AIS end only sets interrupt
        phase = "R4";
        @(negedge clk); ais_in[1] = 1'b1;
        wait_cyc(2); do_read(8'h11);
        @(negedge clk); ais_in[1] = 1'b0;
        wait_cyc(2); do_read(8'h11); do_read(8'h11);

        // R5: violation and overflow latches
        phase = "R5";
        @(negedge clk); bpv_in[1] = 1'b1; ovf_in[0] = 1'b1;
        @(negedge clk); bpv_in[1] = 1'b0; ovf_in[0] = 1'b0;
        wait_cyc(2); do_read(8'h10); do_read(8'h11);

        // R6: auxiliary bit sources per channel
        phase = "R6";
        @(negedge clk); dev_rst_evt = 1'b1;
        @(negedge clk); dev_rst_evt = 1'b0; clk_lost = 1'b1;
        wait_cyc(3); clk_lost = 1'b0;
        do_read(8'h10); do_read(8'h11); do_read(8'h11);

        // R7: every latch source raises the interrupt bit
        phase = "R7";
        @(negedge clk); ovf_in[1] = 1'b1;
        @(negedge clk); ovf_in[1] = 1'b0;
        wait_cyc(2); do_read(8'h11);

        // R8: unmapped address reads zero and clears nothing; channels isolated
        phase = "R8";
        @(negedge clk); bpv_in = 2'b11;
        @(negedge clk); bpv_in = 2'b00;
        do_read(8'h12); do_read(8'h00); do_read(8'h11); do_read(8'h10); do_read(8'h10);

        // R9: set coincident with clearing read survives
        phase = "R9";
        @(negedge clk); bpv_in[0] = 1'b1;
        @(negedge clk); bpv_in[0] = 1'b0;
        @(negedge clk); rd_en = 1'b1; rd_addr = 8'h10; bpv_in[0] = 1'b1; los_in[0] = 1'b1;
        @(negedge clk); rd_en = 1'b0; bpv_in[0] = 1'b0;
        wait_cyc(2); do_read(8'h10); do_read(8'h10);
        @(negedge clk); los_in[0] = 1'b0;
        do_read(8'h10);

        // R10: irq stays until both channels are read
        phase = "R10";
        @(negedge clk); bpv_in = 2'b11;
        @(negedge clk); bpv_in = 2'b00;
        wait_cyc(3); do_read(8'h10); wait_cyc(3); do_read(8'h11); wait_cyc(2);

        // R11: one-cycle pulses between reads
        phase = "R11";
        @(negedge clk); los_in[1] = 1'b1; ais_in[0] = 1'b1;
        @(negedge clk); los_in[1] = 1'b0; ais_in[0] = 1'b0;
        wait_cyc(4); do_read(8'h11); do_read(8'h10); do_read(8'h10);

        // R8: random traffic with reads colliding with events
        phase = "R8";
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            los_in      = (($urandom % 8) == 0) ? ~los_in : los_in;
            ais_in      = (($urandom % 8) == 0) ? 2'($urandom) : ais_in;
            bpv_in      = (($urandom % 10) == 0) ? 2'($urandom) : 2'b00;
            ovf_in      = (($urandom % 12) == 0) ? 2'($urandom) : 2'b00;
            dev_rst_evt = (($urandom % 20) == 0);
            clk_lost    = (($urandom % 16) == 0);
            rd_en       = (($urandom % 4) == 0);
            rd_addr     = 8'h0F + 8'($urandom % 4);
        end
        @(negedge clk); rd_en = 1'b0;

        // R1: reset in mid-run clears everything
        phase = "R1";
        los_in = '0; ais_in = '0; bpv_in = '0; ovf_in = '0;
        @(negedge clk); rst_n = 1'b0;
        wait_cyc(2); rst_n = 1'b1;
        do_read(8'h10); do_read(8'h11);
        wait_cyc(2);
        finish_run();
    end
endmodule